// File: doc/BRIEF.md
# Three-Wire Serial Word Receiver

This block takes a tuner synthesizer's programming word from a three-line serial interface made of data, clock and enable. Bits move into an internal shift register on each falling clock edge seen while enable is high. When enable falls, the word is copied into the output registers, but only if exactly eighteen clock pulses arrived during that enable window. Any other count leaves the outputs as they were. The three lines are sampled by a fast system clock, and edges are found by comparing each line with its value one cycle earlier.

The block also holds the bus-mode selector. A committed three-wire word puts the block in three-wire mode. An address acknowledge from the I2C path puts it back in I2C mode. In I2C mode every register output simply repeats the value the I2C path supplies.

In three-wire mode the outputs behave as follows:
- The divider comes from the word, with its top bit forced low.
- The charge-pump, test, prescaler and drive controls take fixed values.
- The reference ratio code comes from an external 2-bit select input.
- The shared pin-9 output carries the lock indication.

Top module: `tw_word_rx`

## Requirements
- R1: After reset, `tw_mode` is 0, and every register output (`div_ratio`, `port_out`, `pin9_out`, `cp_hi`, `test_en`, `cp_off`, `psc_on`, `os_dis`, `ref_code`) equals its I2C-side input.
- R2: A bit is shifted in on a falling edge of `tw_clk` only while `tw_en` is high. Clock edges while `tw_en` is low have no effect on the next committed word.
- R3: On a falling edge of `tw_en`, the word is committed only if exactly 18 clock pulses were counted in that enable-high window. Windows of 17, 19 or more pulses leave `div_ratio`, `port_out` and `tw_mode` unchanged.
- R4: Field mapping of the 18 serial bits, in transmission order:
  - bit 1 goes to `port_out[1]` (P1);
  - bit 2 goes to `port_out[2]` (P2);
  - bit 3 goes to `port_out[0]` (P0);
  - bits 4 to 17 form the 14-bit scaling factor, most significant bit first;
  - bit 18 is ignored.
- R5: In three-wire mode, `div_ratio[14]` is 0 and `div_ratio[13:0]` is the committed scaling factor.
- R6: In three-wire mode, the controls are fixed at `cp_hi`=1, `test_en`=0, `cp_off`=0, `psc_on`=1 and `os_dis`=0.
- R7: In three-wire mode, `ref_code` follows `ext_ref`. In I2C mode, it follows `i2c_ref`.
- R8: In three-wire mode, `pin9_out` follows `lock_in`. In I2C mode, it follows `i2c_p6`.
- R9: A committed word sets `tw_mode` to 1 in the cycle after enable is seen low. A pulse on `i2c_addr_ack` clears `tw_mode` to 0 one cycle later.
- R10: The pulse counter clears on each rising edge of `tw_en` and saturates above 18. A 50-pulse window, which would wrap a 5-bit counter to 18, is rejected, and a short rejected window does not spoil the window that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tw_data | input | 1 | Serial data line |
| tw_clk | input | 1 | Serial clock line |
| tw_en | input | 1 | Serial enable line |
| i2c_div | input | 15 | Divider value from the I2C path |
| i2c_port | input | 3 | Ports P2..P0 from the I2C path |
| i2c_p6 | input | 1 | Port P6 from the I2C path |
| i2c_cp_hi | input | 1 | High charge-pump current, I2C path |
| i2c_test | input | 1 | Divider test enable, I2C path |
| i2c_cp_off | input | 1 | Charge-pump disable, I2C path |
| i2c_psc | input | 1 | Prescaler enable, I2C path |
| i2c_os | input | 1 | Drive-amplifier disable, I2C path |
| i2c_ref | input | 2 | Reference ratio code, I2C path |
| i2c_addr_ack | input | 1 | One-cycle pulse on a valid I2C address acknowledge |
| ext_ref | input | 2 | Decoded external reference select |
| lock_in | input | 1 | Lock indication from the loop |
| div_ratio | output | 15 | Programmable divider value |
| port_out | output | 3 | Ports P2..P0 |
| pin9_out | output | 1 | P6 in I2C mode, lock in three-wire mode |
| cp_hi | output | 1 | High charge-pump current |
| test_en | output | 1 | Divider test enable |
| cp_off | output | 1 | Charge-pump disable |
| psc_on | output | 1 | Prescaler enable |
| os_dis | output | 1 | Drive-amplifier disable |
| ref_code | output | 2 | Reference ratio code |
| tw_mode | output | 1 | 1 when the three-wire interface owns the outputs |

## Verification
The frame path is driven with windows of 18, 17, 19 and 50 pulses. These separate a correct exact-count check from an off-by-one, from a missing check and from a counter that wraps instead of saturating. Distinct port and scaling-factor patterns, including all ones and alternating bits, tell a correct field order from swapped port bits or a shifted factor. Clock pulses sent while enable is low, and a short window followed by a good one, show whether idle clocks or a stale count leak into the next word. The mode selector is then toggled with an address acknowledge to confirm that the outputs switch between the two sources.

// File: rtl/tw_word_rx.sv
module tw_word_rx #(
  parameter int WORD_LEN = 18,
  parameter int SF_W     = 14,
  parameter int DIV_W    = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tw_data,
  input  logic             tw_clk,
  input  logic             tw_en,
  input  logic [DIV_W-1:0] i2c_div,
  input  logic [2:0]       i2c_port,
  input  logic             i2c_p6,
  input  logic             i2c_cp_hi,
  input  logic             i2c_test,
  input  logic             i2c_cp_off,
  input  logic             i2c_psc,
  input  logic             i2c_os,
  input  logic [1:0]       i2c_ref,
  input  logic             i2c_addr_ack,
  input  logic [1:0]       ext_ref,
  input  logic             lock_in,
  output logic [DIV_W-1:0] div_ratio,
  output logic [2:0]       port_out,
  output logic             pin9_out,
  output logic             cp_hi,
  output logic             test_en,
  output logic             cp_off,
  output logic             psc_on,
  output logic             os_dis,
  output logic [1:0]       ref_code,
  output logic             tw_mode
);
  localparam int CNT_W = $clog2(WORD_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_LEN);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_LEN + 1);

  logic                clk_q, en_q;
  logic [WORD_LEN-1:0] shreg;
  logic [CNT_W-1:0]    cnt;
  logic [SF_W-1:0]     tw_sf;
  logic [2:0]          tw_port;

  wire clk_fall = clk_q & ~tw_clk;
  wire en_rise  = ~en_q & tw_en;
  wire en_fall  = en_q & ~tw_en;
  wire shift_en = clk_fall & tw_en & en_q;
  wire commit   = en_fall & (cnt == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      en_q  <= 1'b0;
      shreg <= '0;
      cnt   <= '0;
    end else begin
      clk_q <= tw_clk;
      en_q  <= tw_en;
      if (en_rise)
        cnt <= '0;
      else if (shift_en) begin
        shreg <= {shreg[WORD_LEN-2:0], tw_data};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tw_sf   <= '0;
      tw_port <= '0;
      tw_mode <= 1'b0;
    end else if (commit) begin
      tw_port[1] <= shreg[WORD_LEN-1];
      tw_port[2] <= shreg[WORD_LEN-2];
      tw_port[0] <= shreg[WORD_LEN-3];
      tw_sf      <= shreg[WORD_LEN-4 -: SF_W];
      tw_mode    <= 1'b1;
    end else if (i2c_addr_ack) begin
      tw_mode <= 1'b0;
    end
  end

  assign div_ratio = tw_mode ? {{(DIV_W-SF_W){1'b0}}, tw_sf} : i2c_div;
  assign port_out  = tw_mode ? tw_port : i2c_port;
  assign pin9_out  = tw_mode ? lock_in : i2c_p6;
  assign cp_hi     = tw_mode ? 1'b1 : i2c_cp_hi;
  assign test_en   = tw_mode ? 1'b0 : i2c_test;
  assign cp_off    = tw_mode ? 1'b0 : i2c_cp_off;
  assign psc_on    = tw_mode ? 1'b1 : i2c_psc;
  assign os_dis    = tw_mode ? 1'b0 : i2c_os;
  assign ref_code  = tw_mode ? ext_ref : i2c_ref;
endmodule

// File: rtl/tw_word_rx_chk.sv
module tw_word_rx_chk #(
  parameter int WORD_LEN = 18,
  parameter int DIV_W    = 15,
  parameter int CNT_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tw_en,
  input logic                i2c_addr_ack,
  input logic                tw_mode,
  input logic [DIV_W-1:0]    div_ratio,
  input logic                cp_hi,
  input logic                test_en,
  input logic                cp_off,
  input logic                psc_on,
  input logic                os_dis,
  input logic [WORD_LEN-1:0] shreg,
  input logic [CNT_W-1:0]    cnt,
  input logic                commit
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tw_en |=> $stable(shreg));
  // R3
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tw_mode) |-> $past(!tw_en));
  // R5
  div_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tw_mode |-> !div_ratio[DIV_W-1]);
  // R6
  fixed_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tw_mode |-> (cp_hi && !test_en && !cp_off && psc_on && !os_dis));
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_addr_ack && !commit) |=> !tw_mode);
  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_LEN + 1));
endmodule

bind tw_word_rx tw_word_rx_chk #(.WORD_LEN(WORD_LEN), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tw_en(tw_en), .i2c_addr_ack(i2c_addr_ack),
  .tw_mode(tw_mode), .div_ratio(div_ratio), .cp_hi(cp_hi), .test_en(test_en),
  .cp_off(cp_off), .psc_on(psc_on), .os_dis(os_dis), .shreg(shreg),
  .cnt(cnt), .commit(commit));

// File: tb/tw_word_rx_test.sv
module tw_word_rx_test;
  logic clk = 0, rst_n = 0;
  logic tw_data = 0, tw_clk = 0, tw_en = 0;
  logic [14:0] i2c_div = 15'h5A5A;
  logic [2:0]  i2c_port = 3'b101;
  logic i2c_p6 = 1, i2c_cp_hi = 0, i2c_test = 1, i2c_cp_off = 1, i2c_psc = 0, i2c_os = 1;
  logic [1:0] i2c_ref = 2'b01, ext_ref = 2'b10;
  logic i2c_addr_ack = 0, lock_in = 0;
  logic [14:0] div_ratio;
  logic [2:0] port_out;
  logic pin9_out, cp_hi, test_en, cp_off, psc_on, os_dis, tw_mode;
  logic [1:0] ref_code;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [14:0] div; logic [2:0] port; logic mode; string req; } exp_t;
  exp_t q[$];
  logic [14:0] m_div = 15'h5A5A;
  logic [2:0]  m_port = 3'b101;
  logic        m_mode = 0;
  event frame_end;

  tw_word_rx uut (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    tw_data = d; tw_clk = 1; cyc(2);
    tw_clk = 0; cyc(2);
  endtask

  task automatic noise(input int k);
    for (int i = 0; i < k; i++) pulse(i[0]);
  endtask

  task automatic send_frame(input int n, input logic [2:0] p, input logic [13:0] sf, input string req);
    exp_t e;
    tw_en = 1; cyc(2);
    for (int i = 0; i < n; i++) begin
      logic b;
      if (i == 0) b = p[1];
      else if (i == 1) b = p[2];
      else if (i == 2) b = p[0];
      else if (i < 17) b = sf[16-i];
      else b = 1'b1;
      pulse(b);
    end
    tw_en = 0; cyc(3);
    if (n == 18) begin m_div = {1'b0, sf}; m_port = p; m_mode = 1; end
    e.div = m_div; e.port = m_port; e.mode = m_mode; e.req = req;
    q.push_back(e);
    -> frame_end;
    cyc(1);
  endtask

  initial begin
    forever begin
      exp_t e;
      @(frame_end);
      e = q.pop_front();
      check({e.req, " div"}, 32'(div_ratio), 32'(e.div));
      check({e.req, " port"}, 32'(port_out), 32'(e.port));
      check({e.req, " mode"}, 32'(tw_mode), 32'(e.mode));
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    // R1 reset state mirrors the I2C side
    check("R1 mode", 32'(tw_mode), 0);
    check("R1 div", 32'(div_ratio), 32'h5A5A);
    check("R1 port", 32'(port_out), 32'b101);
    check("R1 ctrl", 32'({cp_hi, test_en, cp_off, psc_on, os_dis, pin9_out}), 32'b011011);
    check("R1 ref", 32'(ref_code), 32'b01);
    // R3 short and long windows rejected
    send_frame(17, 3'b011, 14'h1234, "R3 17 pulses");
    send_frame(19, 3'b011, 14'h1234, "R3 19 pulses");
    // R4 field order
    send_frame(18, 3'b110, 14'h2A55, "R4 word A");
    send_frame(18, 3'b001, 14'h1555, "R4 word B");
    // R5 all-ones factor, top bit stays low
    send_frame(18, 3'b111, 14'h3FFF, "R5 all ones");
    check("R5 msb", 32'(div_ratio[14]), 0);
    // R2 idle clocks ignored
    noise(7);
    send_frame(18, 3'b010, 14'h0F0F, "R2 after idle clocks");
    // R10 saturation and clear on new window
    send_frame(50, 3'b100, 14'h0001, "R10 50 pulses");
    send_frame(10, 3'b100, 14'h0002, "R10 short window");
    send_frame(18, 3'b100, 14'h0003, "R10 good after short");
    // R6 fixed controls
    check("R6 ctrl", 32'({cp_hi, test_en, cp_off, psc_on, os_dis}), 32'b10010);
    // R7 reference from external select
    ext_ref = 2'b00; cyc(1);
    check("R7 ext 00", 32'(ref_code), 0);
    ext_ref = 2'b10; cyc(1);
    check("R7 ext 10", 32'(ref_code), 2);
    // R8 pin9 is lock in this mode
    lock_in = 1; cyc(1);
    check("R8 lock 1", 32'(pin9_out), 1);
    lock_in = 0; cyc(1);
    check("R8 lock 0", 32'(pin9_out), 0);
    // R9 acknowledge hands outputs back to I2C
    i2c_addr_ack = 1; cyc(1); i2c_addr_ack = 0; cyc(1);
    check("R9 mode cleared", 32'(tw_mode), 0);
    check("R9 div back", 32'(div_ratio), 32'h5A5A);
    check("R8 p6 in I2C", 32'(pin9_out), 1);
    check("R7 i2c ref", 32'(ref_code), 1);
    m_div = 15'h5A5A; m_port = 3'b101; m_mode = 0;
    send_frame(18, 3'b000, 14'h0100, "R9 re-enter three-wire");
    cyc(2);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule